// File: doc/BRIEF.md
# Packed FMA Lane Controller

This block steers operands into a bank of eight 64-bit fused multiply-add lanes and merges what the lanes return. It accepts one operation at a time through a valid/ready handshake. An operation carries three 512-bit vectors: the destination, which is also a source, and two further sources. It also carries an operand-order code, a vector-length code, a write mask with enable and merge/zero controls, broadcast and memory-source flags, and two rounding fields. The block does no arithmetic of its own. It sends a multiplicand, a multiplier, a sign-adjusted addend and a rounding mode to the lanes, together with a per-lane enable vector.

The lanes are external. When they answer, the block merges their results into the held destination image. Lanes that the mask turns off keep their old value in merge mode and are cleared in zeroing mode. Lanes beyond the vector length are cleared. The exception flags of the lanes that were enabled are ORed together. The merged vector and the flags come out in a registered result with a one-cycle valid pulse. Only one operation is outstanding at a time, so results come back in issue order.

Top module: `fma_lane_ctrl`

## Requirements
- R1: Order code 0 sends (multiplicand, multiplier, addend) = (dest, src3, src2). Code 1 sends (src2, dest, src3). Codes 2 and 3 send (src2, src3, dest).
- R2: On even lanes the addend goes out unchanged. On odd lanes the addend goes out with bit 63 of the lane inverted. Multiplicand and multiplier are never altered.
- R3: When the memory-source flag and the broadcast flag are both 1, src3 bits [63:0] replace the src3 element of every lane, whatever role src3 plays in the selected order. Otherwise each lane takes its own src3 bits [64j+63:64j].
- R4: The length code sets the active lanes: code 0 gives lanes 0-1, code 1 gives lanes 0-3, codes 2 and 3 give all eight. The lane enable bit j is 1 when lane j is active and either mask bit j is 1 or the mask enable is 0.
- R5: In the result, an enabled lane carries the lane's returned value. An active lane that is masked off keeps its destination value when the zero flag is 0, and becomes zero when the zero flag is 1.
- R6: Every result bit in lanes beyond the active count is zero, whether or not masking is on.
- R7: The rounding mode is the embedded field when the memory-source flag is 0, the length code is 2 or 3 and the broadcast flag is 1. In all other cases it is the global field.
- R8: The 5-bit flag output is the OR of the per-lane flag groups (lane j at bits [5j+4:5j]) over the enabled lanes only.
- R9: The ready output is 1 when the block is idle and 0 from acceptance until the result is delivered. Each accepted request produces exactly one single-cycle lane-valid pulse, on the edge that accepts it. Each lane return produces exactly one single-cycle result-valid pulse, on the edge that samples it.
- R10: After reset, ready is 1, both valid outputs are 0, and the result and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| order_i | input | 2 | Operand-order code |
| vlen_i | input | 2 | Vector-length code |
| mask_i | input | 8 | Per-lane write mask |
| mask_en_i | input | 1 | Mask enable |
| zero_mode_i | input | 1 | 1 = zero masked lanes, 0 = keep them |
| bcast_i | input | 1 | Broadcast / embedded-rounding flag |
| mem_src_i | input | 1 | Third source comes from memory |
| rc_embed_i | input | 2 | Per-operation rounding field |
| rc_global_i | input | 2 | Global rounding field |
| dst_i | input | 512 | Destination / first source |
| src2_i | input | 512 | Second source |
| src3_i | input | 512 | Third source |
| lane_valid_o | output | 1 | Operands to lanes valid |
| lane_en_o | output | 8 | Per-lane enable |
| lane_a_o | output | 512 | Multiplicands |
| lane_b_o | output | 512 | Multipliers |
| lane_c_o | output | 512 | Sign-adjusted addends |
| lane_rm_o | output | 2 | Rounding mode for the lanes |
| lane_valid_i | input | 1 | Lane results valid |
| lane_res_i | input | 512 | Lane results |
| lane_flags_i | input | 40 | Five flags per lane |
| res_valid_o | output | 1 | Merged result valid |
| res_o | output | 512 | Merged destination |
| flags_o | output | 5 | ORed exception flags |

## Verification
Some properties are checked on every clock. A result has all-zero lanes beyond the active length. Masked active lanes either hold the stored destination or are zero, depending on the mode. Lane enables never reach past the active length. Both valid outputs are single-cycle pulses.

Other behaviour can only be shown by the bench's scenarios. These are the operand routing for each order code and the sign inversion on odd addends. They also cover broadcast versus per-lane src3, the rounding-field choice, flag masking, and the lane results actually landing in the enabled lanes. For these the bench compares against values it computes itself. A stub stands in for the lanes and returns a sum of the operands with several cycles of delay.

// File: rtl/fma_lane_pkg.sv
package fma_lane_pkg;
  localparam int LANES_DEF = 8;
  localparam int LANE_W_DEF = 64;
  localparam int NFLAG_DEF = 5;
  localparam int RM_W_DEF = 2;

  typedef enum logic [1:0] {
    ORD_DST_S3 = 2'd0,   // dst*src3 +- src2
    ORD_S2_DST = 2'd1,   // src2*dst +- src3
    ORD_S2_S3  = 2'd2,   // src2*src3 +- dst
    ORD_S2_S3B = 2'd3
  } order_e;
endpackage

// File: rtl/fma_operand_steer.sv
module fma_operand_steer
  import fma_lane_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic [1:0]       order_i,
  input  logic             bcast_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [VEC_W-1:0] src2_i,
  input  logic [VEC_W-1:0] src3_i,
  output logic [VEC_W-1:0] a_o,
  output logic [VEC_W-1:0] b_o,
  output logic [VEC_W-1:0] c_o
);
  order_e ord;
  assign ord = order_e'(order_i);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] d, s2, s3, c_raw;
    assign d  = dst_i[j*LANE_W +: LANE_W];
    assign s2 = src2_i[j*LANE_W +: LANE_W];
    assign s3 = bcast_i ? src3_i[LANE_W-1:0] : src3_i[j*LANE_W +: LANE_W];

    always_comb begin
      unique case (ord)
        ORD_DST_S3: begin
          a_o[j*LANE_W +: LANE_W] = d;
          b_o[j*LANE_W +: LANE_W] = s3;
          c_raw = s2;
        end
        ORD_S2_DST: begin
          a_o[j*LANE_W +: LANE_W] = s2;
          b_o[j*LANE_W +: LANE_W] = d;
          c_raw = s3;
        end
        default: begin
          a_o[j*LANE_W +: LANE_W] = s2;
          b_o[j*LANE_W +: LANE_W] = s3;
          c_raw = d;
        end
      endcase
    end

    // odd lanes subtract: flip addend sign only
    if (j % 2 == 1) begin : g_odd
      assign c_o[j*LANE_W +: LANE_W] = {~c_raw[LANE_W-1], c_raw[LANE_W-2:0]};
    end else begin : g_even
      assign c_o[j*LANE_W +: LANE_W] = c_raw;
    end
  end
endmodule

// File: rtl/fma_result_merge.sv
module fma_result_merge
  import fma_lane_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF,
  parameter int NFLAG  = NFLAG_DEF,
  localparam int VEC_W = LANES * LANE_W,
  localparam int FLG_W = LANES * NFLAG
) (
  input  logic [LANES-1:0] en_i,
  input  logic [LANES-1:0] active_i,
  input  logic             zero_mode_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [VEC_W-1:0] res_i,
  input  logic [FLG_W-1:0] flags_i,
  output logic [VEC_W-1:0] merged_o,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] flg_part [LANES+1];
  assign flg_part[0] = '0;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      if (!active_i[j])
        merged_o[j*LANE_W +: LANE_W] = '0;
      else if (en_i[j])
        merged_o[j*LANE_W +: LANE_W] = res_i[j*LANE_W +: LANE_W];
      else if (zero_mode_i)
        merged_o[j*LANE_W +: LANE_W] = '0;
      else
        merged_o[j*LANE_W +: LANE_W] = dst_i[j*LANE_W +: LANE_W];
    end
    assign flg_part[j+1] = flg_part[j] |
                           (en_i[j] ? flags_i[j*NFLAG +: NFLAG] : '0);
  end

  assign flags_o = flg_part[LANES];
endmodule

// File: rtl/fma_lane_ctrl.sv
module fma_lane_ctrl
  import fma_lane_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF,
  parameter int NFLAG  = NFLAG_DEF,
  parameter int RM_W   = RM_W_DEF,
  localparam int VEC_W = LANES * LANE_W,
  localparam int FLG_W = LANES * NFLAG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       order_i,
  input  logic [1:0]       vlen_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             mask_en_i,
  input  logic             zero_mode_i,
  input  logic             bcast_i,
  input  logic             mem_src_i,
  input  logic [RM_W-1:0]  rc_embed_i,
  input  logic [RM_W-1:0]  rc_global_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [VEC_W-1:0] src2_i,
  input  logic [VEC_W-1:0] src3_i,
  output logic             lane_valid_o,
  output logic [LANES-1:0] lane_en_o,
  output logic [VEC_W-1:0] lane_a_o,
  output logic [VEC_W-1:0] lane_b_o,
  output logic [VEC_W-1:0] lane_c_o,
  output logic [RM_W-1:0]  lane_rm_o,
  input  logic             lane_valid_i,
  input  logic [VEC_W-1:0] lane_res_i,
  input  logic [FLG_W-1:0] lane_flags_i,
  output logic             res_valid_o,
  output logic [VEC_W-1:0] res_o,
  output logic [NFLAG-1:0] flags_o
);
  logic busy_q, accept, done;
  logic [LANES-1:0] active_d, en_d, ctx_active_q;
  logic             ctx_zero_q;
  logic [VEC_W-1:0] ctx_dst_q;
  logic [VEC_W-1:0] a_d, b_d, c_d, merged;
  logic [NFLAG-1:0] flags_d;
  logic [RM_W-1:0]  rm_d;

  assign req_ready_o = !busy_q;
  assign accept      = req_valid_i && req_ready_o;
  assign done        = lane_valid_i && busy_q;

  for (genvar j = 0; j < LANES; j++) begin : g_act
    assign active_d[j] = 32'(j) < (32'd2 << vlen_i);
    assign en_d[j]     = active_d[j] && (!mask_en_i || mask_i[j]);
  end

  // embedded rounding only for full-length register form with the flag set
  assign rm_d = (!mem_src_i && vlen_i[1] && bcast_i) ? rc_embed_i : rc_global_i;

  fma_operand_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_steer (
    .order_i (order_i),
    .bcast_i (bcast_i && mem_src_i),
    .dst_i   (dst_i),
    .src2_i  (src2_i),
    .src3_i  (src3_i),
    .a_o     (a_d),
    .b_o     (b_d),
    .c_o     (c_d)
  );

  fma_result_merge #(.LANES(LANES), .LANE_W(LANE_W), .NFLAG(NFLAG)) u_merge (
    .en_i        (lane_en_o),
    .active_i    (ctx_active_q),
    .zero_mode_i (ctx_zero_q),
    .dst_i       (ctx_dst_q),
    .res_i       (lane_res_i),
    .flags_i     (lane_flags_i),
    .merged_o    (merged),
    .flags_o     (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      lane_valid_o <= 1'b0;
      lane_en_o    <= '0;
      lane_a_o     <= '0;
      lane_b_o     <= '0;
      lane_c_o     <= '0;
      lane_rm_o    <= '0;
      ctx_active_q <= '0;
      ctx_zero_q   <= 1'b0;
      ctx_dst_q    <= '0;
      res_valid_o  <= 1'b0;
      res_o        <= '0;
      flags_o      <= '0;
    end else begin
      lane_valid_o <= accept;
      res_valid_o  <= done;
      if (accept) begin
        busy_q       <= 1'b1;
        lane_en_o    <= en_d;
        lane_a_o     <= a_d;
        lane_b_o     <= b_d;
        lane_c_o     <= c_d;
        lane_rm_o    <= rm_d;
        ctx_active_q <= active_d;
        ctx_zero_q   <= zero_mode_i;
        ctx_dst_q    <= dst_i;
      end else if (done) begin
        busy_q  <= 1'b0;
        res_o   <= merged;
        flags_o <= flags_d;
      end
    end
  end

  AST_LANE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_o |=> !lane_valid_o);                          // R9
  AST_RES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);                            // R9
  AST_EN_IN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_o |-> (lane_en_o & ~ctx_active_q) == '0);      // R4

  for (genvar j = 0; j < LANES; j++) begin : g_ast
    AST_ABOVE_LEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o && !ctx_active_q[j]) |-> res_o[j*LANE_W +: LANE_W] == '0);  // R6
    AST_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o && ctx_active_q[j] && !lane_en_o[j] && ctx_zero_q)
        |-> res_o[j*LANE_W +: LANE_W] == '0);                 // R5
    AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o && ctx_active_q[j] && !lane_en_o[j] && !ctx_zero_q)
        |-> res_o[j*LANE_W +: LANE_W] == ctx_dst_q[j*LANE_W +: LANE_W]);  // R5
  end
endmodule

// File: tb/fma_lane_ctrl_tb.sv
module fma_lane_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;
  localparam int W = 64;
  localparam int V = L * W;
  localparam int LAT = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [1:0] order_i = '0, vlen_i = '0;
  logic [L-1:0] mask_i = '0;
  logic mask_en_i = 1'b0, zero_mode_i = 1'b0, bcast_i = 1'b0, mem_src_i = 1'b0;
  logic [1:0] rc_embed_i = '0, rc_global_i = '0;
  logic [V-1:0] dst_i = '0, src2_i = '0, src3_i = '0;
  logic lane_valid_o;
  logic [L-1:0] lane_en_o;
  logic [V-1:0] lane_a_o, lane_b_o, lane_c_o;
  logic [1:0] lane_rm_o;
  logic lane_valid_i = 1'b0;
  logic [V-1:0] lane_res_i = '0;
  logic [L*5-1:0] lane_flags_i = '0;
  logic res_valid_o;
  logic [V-1:0] res_o;
  logic [4:0] flags_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cycles <= cycles + 1;

  fma_lane_ctrl dut_i (.*);

  // lane stub: result = a+b+c per lane, flags = low bits of a^b^c
  int stub_cnt = 0;
  always @(posedge clk_i) begin
    lane_valid_i <= 1'b0;
    if (lane_valid_o) begin
      stub_cnt <= LAT;
      for (int j = 0; j < L; j++) begin
        lane_res_i[j*W +: W] <= lane_a_o[j*W +: W] + lane_b_o[j*W +: W] + lane_c_o[j*W +: W];
        lane_flags_i[j*5 +: 5] <= lane_a_o[j*W +: 5] ^ lane_b_o[j*W +: 5] ^ lane_c_o[j*W +: 5];
      end
    end else if (stub_cnt > 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) lane_valid_i <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [V-1:0] act, input logic [V-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic [V-1:0] ea, eb, ec, eres;
  logic [L-1:0] een;
  logic [1:0]   erm;
  logic [4:0]   eflg;

  task automatic compute_exp();
    for (int j = 0; j < L; j++) begin
      logic [W-1:0] d, s2, s3, a, b, c, r;
      logic act;
      d  = dst_i[j*W +: W];
      s2 = src2_i[j*W +: W];
      s3 = (mem_src_i && bcast_i) ? src3_i[W-1:0] : src3_i[j*W +: W];
      case (order_i)
        2'd0: begin a = d;  b = s3; c = s2; end
        2'd1: begin a = s2; b = d;  c = s3; end
        default: begin a = s2; b = s3; c = d; end
      endcase
      if (j % 2 == 1) c[W-1] = ~c[W-1];
      ea[j*W +: W] = a; eb[j*W +: W] = b; ec[j*W +: W] = c;
      act = (vlen_i == 2'd0) ? (j < 2) : (vlen_i == 2'd1) ? (j < 4) : 1'b1;
      een[j] = act && (!mask_en_i || mask_i[j]);
      r = a + b + c;
      if (!act) eres[j*W +: W] = '0;
      else if (een[j]) eres[j*W +: W] = r;
      else eres[j*W +: W] = zero_mode_i ? '0 : d;
    end
    eflg = '0;
    for (int j = 0; j < L; j++)
      if (een[j]) eflg |= ea[j*W +: 5] ^ eb[j*W +: 5] ^ ec[j*W +: 5];
    erm = (!mem_src_i && vlen_i[1] && bcast_i) ? rc_embed_i : rc_global_i;
  endtask

  task automatic run_op();
    int t;
    @(negedge clk_i);
    compute_exp();
    req_valid_i = 1'b1;
    chk(req_ready_o, "R9 ready idle", V'(req_ready_o), V'(1));
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(lane_valid_o, "R9 lane pulse", V'(lane_valid_o), V'(1));
    chk(!req_ready_o, "R9 ready low busy", V'(req_ready_o), V'(0));
    chk(lane_a_o == ea, "R1 multiplicand", lane_a_o, ea);
    chk(lane_b_o == eb, "R1 R3 multiplier", lane_b_o, eb);
    chk(lane_c_o == ec, "R2 R3 addend", lane_c_o, ec);
    chk(lane_en_o == een, "R4 lane enable", V'(lane_en_o), V'(een));
    chk(lane_rm_o == erm, "R7 rounding", V'(lane_rm_o), V'(erm));
    t = 0;
    while (!res_valid_o && t < 50) begin @(negedge clk_i); t++; end
    chk(res_valid_o, "R9 result pulse", V'(res_valid_o), V'(1));
    chk(res_o == eres, "R5 R6 merged result", res_o, eres);
    chk(flags_o == eflg, "R8 flags", V'(flags_o), V'(eflg));
    @(negedge clk_i);
    chk(!res_valid_o, "R9 single result", V'(res_valid_o), V'(0));
  endtask

  function automatic logic [V-1:0] rnd_vec();
    logic [V-1:0] v;
    for (int k = 0; k < V/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic set_op(input logic [1:0] ord, input logic [1:0] vl, input logic [7:0] m,
                        input bit men, input bit zm, input bit bc, input bit ms);
    order_i = ord; vlen_i = vl; mask_i = m; mask_en_i = men; zero_mode_i = zm;
    bcast_i = bc; mem_src_i = ms;
    rc_embed_i = 2'($urandom); rc_global_i = 2'($urandom);
    if (rc_embed_i == rc_global_i) rc_embed_i = ~rc_global_i;
    dst_i = rnd_vec(); src2_i = rnd_vec(); src3_i = rnd_vec();
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(req_ready_o && !lane_valid_o && !res_valid_o, "R10 reset handshake",
        V'({req_ready_o, lane_valid_o, res_valid_o}), V'(3'b100));
    chk(res_o == '0 && flags_o == '0, "R10 reset outputs", res_o, '0);
    rst_ni = 1'b1;
    // R1 each order code, unmasked full length
    for (int o = 0; o < 4; o++) begin set_op(2'(o), 2'd2, 8'h00, 0, 0, 0, 0); run_op(); end
    // R4 R5 R6 short lengths, merge and zero masking
    set_op(2'd0, 2'd0, 8'h02, 1, 0, 0, 0); run_op();
    set_op(2'd1, 2'd1, 8'h05, 1, 1, 0, 0); run_op();
    set_op(2'd2, 2'd1, 8'hF0, 1, 0, 0, 0); run_op();   // mask only above length
    set_op(2'd0, 2'd2, 8'h00, 1, 1, 0, 0); run_op();   // all masked, zero
    // R6 legacy unmasked short forms
    set_op(2'd1, 2'd0, 8'h00, 0, 0, 0, 0); run_op();
    // R3 broadcast in every role
    for (int o = 0; o < 3; o++) begin set_op(2'(o), 2'd2, 8'h00, 0, 0, 1, 1); run_op(); end
    // R7 register form, full length, flag set: embedded rounding, no broadcast
    set_op(2'd0, 2'd2, 8'h00, 0, 0, 1, 0); run_op();
    set_op(2'd0, 2'd1, 8'h00, 0, 0, 1, 0); run_op();   // short length: global
    set_op(2'd0, 2'd3, 8'h3C, 1, 0, 1, 0); run_op();
    // random mix
    for (int n = 0; n < 60; n++) begin
      set_op(2'($urandom), 2'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom));
      run_op();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule